// File: doc/BRIEF.md
# Four-Mode Timer/Counter with Two-Stage Prescaler

This block holds two 8-bit counters, a low byte and a high byte, and a shared two-stage prescaler. Each unit of the system cycle tick `cyc_tick` advances a fixed 2-bit divider. Each wrap of that divider advances an 8-bit divider whose terminal value software can program. A mode field selects one of four arrangements of the two bytes:

- two independent prescaled 8-bit timers;
- a prescaled 8-bit timer on the low byte and an 8-bit event counter on the high byte;
- one cascaded 16-bit prescaled timer;
- one cascaded 16-bit counter of external events.

External events arrive on `evt_in`. They pass through a two-flop synchronizer and are counted on their rising edge.

Software programs the block through a small write port that selects one of four registers. Each byte, or the cascaded pair, counts from zero up to its match value. On the increment that follows, it returns to zero and raises a one-cycle pulse. That pulse sets a sticky flag which an interrupt controller samples. The low byte and the high byte have separate pulse and flag outputs.

Top module: `quad_mode_tmr`

## Requirements
- R1: A write with `wr_en`=1 loads the register chosen by `wr_sel`: 0 = mode (`wr_data[1:0]`), 1 = prescaler terminal P, 2 = low match ML, 3 = high match MH. After reset the mode is 0, P is 0, and ML and MH are 255.
- R2: The prescaled tick fires once every 4*(P+1) cycles in which `cyc_tick`=1. While `cyc_tick`=0 the prescaler and the timer paths do not advance.
- R3: A split byte with match M counts its increments. On increment number M+1 (and every M+1 after it) it returns to zero and `*_pulse` is high for that one cycle. M=0 pulses on every increment.
- R4: Mode 0: both bytes count prescaled ticks independently. The low byte pulses every 4*(P+1)*(ML+1) cycles and the high byte pulses every 4*(P+1)*(MH+1) cycles.
- R5: Mode 1: the low byte is a prescaled timer with match ML. The high byte counts synchronized event edges and pulses on every (MH+1)-th edge.
- R6: Mode 2: the bytes form one 16-bit timer, with the low byte carrying into the high byte. When the value reaches 256*MH+ML, the next prescaled tick clears both bytes and pulses `hi_pulse`. `lo_pulse` stays low.
- R7: Mode 3: same as R6, but the increment is a synchronized event edge instead of a prescaled tick.
- R8: A rising edge on `evt_in` applied just before clock edge A is counted at edge A+2. Its pulse is sampled in the cycle that ends at A+2. A level held high counts only once.
- R9: Writing the mode register clears both bytes and both prescaler stages at that edge. All timing in R2 to R7 counts from that edge.
- R10: A pulse sets its flag at the next edge, and the flag stays set until `clr_lo` or `clr_hi` is high at an edge. If a pulse and a clear occur in the same cycle, the flag is set.
- R11: After reset both flags and both pulses are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cyc_tick | input | 1 | One-cycle enable per instruction cycle |
| evt_in | input | 1 | Asynchronous external event input |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select: mode, prescaler, low match, high match |
| wr_data | input | 8 | Write data |
| clr_lo | input | 1 | Clear the low-byte flag |
| clr_hi | input | 1 | Clear the high-byte flag |
| lo_pulse | output | 1 | One-cycle low-byte match pulse |
| hi_pulse | output | 1 | One-cycle high-byte or 16-bit match pulse |
| lo_flag | output | 1 | Sticky low-byte interrupt request |
| hi_flag | output | 1 | Sticky high-byte interrupt request |

## Verification
A wrong count, wrong prescaler state or missing carry changes when the next match pulse appears, relative to the last mode write. Each pulse is compared to its exact expected cycle, so such an error is caught at the first expected pulse, at most one full period later. A synchronizer that is off by one stage moves every event-driven pulse by one cycle. An extra or missing edge changes which event number triggers the pulse. A wrong flag priority shows on the cycle right after a pulse that coincides with a clear.

// File: rtl/qmt_pkg.sv
package qmt_pkg;

  typedef enum logic [1:0] {
    QM_SPLIT   = 2'd0,
    QM_TMR_EVT = 2'd1,
    QM_CAS_TMR = 2'd2,
    QM_CAS_EVT = 2'd3
  } qmt_mode_e;

  localparam logic [1:0] SEL_MODE = 2'd0;
  localparam logic [1:0] SEL_PSC  = 2'd1;
  localparam logic [1:0] SEL_MLO  = 2'd2;
  localparam logic [1:0] SEL_MHI  = 2'd3;

  function automatic logic is_cascaded(input qmt_mode_e m);
    return (m == QM_CAS_TMR) || (m == QM_CAS_EVT);
  endfunction

  function automatic logic low_counts_events(input qmt_mode_e m);
    return m == QM_CAS_EVT;
  endfunction

  function automatic logic high_counts_events(input qmt_mode_e m);
    return m == QM_TMR_EVT;
  endfunction

endpackage

// File: rtl/qmt_prescaler.sv
module qmt_prescaler #(
  parameter int FIX_W = 2,
  parameter int PSC_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             cyc_tick,
  input  logic [PSC_W-1:0] reload,
  output logic             pre_tick
);
  localparam logic [FIX_W-1:0] FIX_LAST = '1;

  logic [FIX_W-1:0] fcnt;
  logic [PSC_W-1:0] pcnt;
  logic             tick_fix;

  assign tick_fix = cyc_tick && (fcnt == FIX_LAST);
  assign pre_tick = tick_fix && (pcnt >= reload);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fcnt <= '0;
      pcnt <= '0;
    end else if (clr) begin
      fcnt <= '0;
      pcnt <= '0;
    end else begin
      if (cyc_tick) fcnt <= fcnt + 1'b1;
      if (tick_fix) pcnt <= pre_tick ? '0 : pcnt + 1'b1;
    end
  end

  // R2
  psc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_fix && !pre_tick && !clr) |=> pcnt == $past(pcnt) + 1'b1);

  // R2
  psc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cyc_tick && !clr) |=> ($stable(fcnt) && $stable(pcnt)));

endmodule

// File: rtl/qmt_evt_sync.sv
module qmt_evt_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic evt_async,
  output logic evt_rise
);
  logic s1, s2, s3;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= 1'b0;
      s2 <= 1'b0;
      s3 <= 1'b0;
    end else begin
      s1 <= evt_async;
      s2 <= s1;
      s3 <= s2;
    end
  end

  assign evt_rise = s2 && !s3;

  // R8
  evt_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_rise |=> !evt_rise);

endmodule

// File: rtl/qmt_byte_cnt.sv
module qmt_byte_cnt #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         zero,
  input  logic         inc,
  input  logic [W-1:0] limit,
  output logic [W-1:0] cnt,
  output logic         wrap
);
  function automatic logic at_end(input logic [W-1:0] c, input logic [W-1:0] l);
    return c >= l;
  endfunction

  assign wrap = inc && at_end(cnt, limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (zero)   cnt <= '0;
    else if (inc)    cnt <= wrap ? '0 : cnt + 1'b1;
  end

  // R3
  bcnt_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap && !zero) |=> cnt == '0);

  // R2
  bcnt_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!inc && !zero) |=> $stable(cnt));

  // R9
  bcnt_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    zero |=> cnt == '0);

endmodule

// File: rtl/quad_mode_tmr.sv
module quad_mode_tmr #(
  parameter int CNT_W = 8,
  parameter int PSC_W = 8,
  parameter int FIX_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cyc_tick,
  input  logic             evt_in,
  input  logic             wr_en,
  input  logic [1:0]       wr_sel,
  input  logic [CNT_W-1:0] wr_data,
  input  logic             clr_lo,
  input  logic             clr_hi,
  output logic             lo_pulse,
  output logic             hi_pulse,
  output logic             lo_flag,
  output logic             hi_flag
);
  import qmt_pkg::*;

  localparam int FULL_W = 2 * CNT_W;
  localparam logic [CNT_W-1:0] CNT_ALL = '1;

  qmt_mode_e        mode_q;
  logic [PSC_W-1:0] psc_q;
  logic [CNT_W-1:0] mlo_q, mhi_q;
  logic             mode_wr;

  assign mode_wr = wr_en && (wr_sel == SEL_MODE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= QM_SPLIT;
      psc_q  <= '0;
      mlo_q  <= CNT_ALL;
      mhi_q  <= CNT_ALL;
    end else if (wr_en) begin
      case (wr_sel)
        SEL_MODE: mode_q <= qmt_mode_e'(wr_data[1:0]);
        SEL_PSC:  psc_q  <= PSC_W'(wr_data);
        SEL_MLO:  mlo_q  <= wr_data;
        default:  mhi_q  <= wr_data;
      endcase
    end
  end

  logic pre_tick, evt_rise;

  qmt_prescaler #(.FIX_W(FIX_W), .PSC_W(PSC_W)) u_psc (
    .clk(clk), .rst_n(rst_n), .clr(mode_wr), .cyc_tick(cyc_tick),
    .reload(psc_q), .pre_tick(pre_tick)
  );

  qmt_evt_sync u_sync (
    .clk(clk), .rst_n(rst_n), .evt_async(evt_in), .evt_rise(evt_rise)
  );

  logic             cascade, full_hit;
  logic             lo_inc, hi_inc, lo_wrap, hi_wrap, lo_zero, hi_zero;
  logic [CNT_W-1:0] lo_cnt, hi_cnt, lo_lim, hi_lim;
  logic [FULL_W-1:0] full_cnt, full_match;

  assign cascade    = is_cascaded(mode_q);
  assign lo_inc     = low_counts_events(mode_q) ? evt_rise : pre_tick;
  assign hi_inc     = cascade ? lo_wrap
                    : (high_counts_events(mode_q) ? evt_rise : pre_tick);
  assign full_cnt   = {hi_cnt, lo_cnt};
  assign full_match = {mhi_q, mlo_q};
  assign full_hit   = cascade && lo_inc && (full_cnt >= full_match);
  assign lo_lim     = cascade ? CNT_ALL : mlo_q;
  assign hi_lim     = cascade ? CNT_ALL : mhi_q;
  assign lo_zero    = mode_wr || full_hit;
  assign hi_zero    = mode_wr || full_hit;

  qmt_byte_cnt #(.W(CNT_W)) u_lo (
    .clk(clk), .rst_n(rst_n), .zero(lo_zero), .inc(lo_inc),
    .limit(lo_lim), .cnt(lo_cnt), .wrap(lo_wrap)
  );

  qmt_byte_cnt #(.W(CNT_W)) u_hi (
    .clk(clk), .rst_n(rst_n), .zero(hi_zero), .inc(hi_inc),
    .limit(hi_lim), .cnt(hi_cnt), .wrap(hi_wrap)
  );

  assign lo_pulse = !cascade && lo_wrap;
  assign hi_pulse = cascade ? full_hit : hi_wrap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_flag <= 1'b0;
      hi_flag <= 1'b0;
    end else begin
      if (lo_pulse)    lo_flag <= 1'b1;
      else if (clr_lo) lo_flag <= 1'b0;
      if (hi_pulse)    hi_flag <= 1'b1;
      else if (clr_hi) hi_flag <= 1'b0;
    end
  end

  // R10
  lo_flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lo_pulse |=> lo_flag);

  // R10
  hi_flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hi_pulse |=> hi_flag);

  // R10
  hi_flag_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hi_flag) |-> $past(hi_pulse));

  // R6
  cas_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cascade && lo_wrap && !lo_zero) |=> hi_cnt == $past(hi_cnt) + 1'b1);

endmodule

// File: tb/quad_mode_tmr_tb.sv
module quad_mode_tmr_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cyc_tick = 1'b1;
  logic evt_in = 1'b0;
  logic wr_en = 1'b0;
  logic [1:0] wr_sel = 2'd0;
  logic [7:0] wr_data = 8'd0;
  logic clr_lo = 1'b0, clr_hi = 1'b0;
  logic lo_pulse, hi_pulse, lo_flag, hi_flag;

  int checks = 0, fails = 0;
  int since = 0;
  bit armed = 1'b0;
  int exp_lo[$], exp_hi[$];
  int seen = 0, pushed = 0;
  string cur_tag = "";

  always #(CLK_PERIOD/2) clk = ~clk;

  quad_mode_tmr u_dut (
    .clk(clk), .rst_n(rst_n), .cyc_tick(cyc_tick), .evt_in(evt_in),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .clr_lo(clr_lo), .clr_hi(clr_hi),
    .lo_pulse(lo_pulse), .hi_pulse(hi_pulse),
    .lo_flag(lo_flag), .hi_flag(hi_flag)
  );

  always @(posedge clk)
    if (wr_en && wr_sel == 2'd0) since <= 0;
    else since <= since + 1;

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // monitor: pops the expected cycle of each pulse
  always @(negedge clk) begin
    if (armed) begin
      if (lo_pulse) begin
        seen++;
        if (exp_lo.size() == 0) check({cur_tag, " lo unexpected"}, since + 1, -1);
        else check({cur_tag, " lo"}, since + 1, exp_lo.pop_front());
      end
      if (hi_pulse) begin
        seen++;
        if (exp_hi.size() == 0) check({cur_tag, " hi unexpected"}, since + 1, -1);
        else check({cur_tag, " hi"}, since + 1, exp_hi.pop_front());
      end
    end
  end

  task automatic wr(input logic [1:0] sel, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(posedge clk);
    #1 wr_en = 1'b0;
  endtask

  task automatic push_every(input bit hi, input int per, input int ncyc);
    for (int n = per; n <= ncyc; n += per) begin
      if (hi) exp_hi.push_back(n); else exp_lo.push_back(n);
      pushed++;
    end
  endtask

  // driver: programs a case, predicts every pulse, then runs it
  task automatic run_case(input string tag, input int mode, input int p,
                          input int ml, input int mh, input int ncyc,
                          input int nevt, input bit tick_on);
    int t, per;
    armed = 1'b0;
    cur_tag = tag;
    exp_lo.delete(); exp_hi.delete();
    seen = 0; pushed = 0;
    wr(2'd1, 8'(p)); wr(2'd2, 8'(ml)); wr(2'd3, 8'(mh));
    t = 4 * (p + 1);
    if (tick_on) begin
      if (mode == 0) begin
        push_every(1'b0, t * (ml + 1), ncyc);
        push_every(1'b1, t * (mh + 1), ncyc);
      end else if (mode == 1) begin
        push_every(1'b0, t * (ml + 1), ncyc);
      end else if (mode == 2) begin
        push_every(1'b1, t * (256 * mh + ml + 1), ncyc);
      end
    end
    per = (mode == 1) ? mh + 1 : 256 * mh + ml + 1;
    wr(2'd0, 8'(mode));
    armed = 1'b1;
    for (int k = 1; k <= ncyc; k++) begin
      @(negedge clk);
      if (nevt > 0) begin
        evt_in = (k <= 4 * nevt) && (((k - 1) % 4) < 2);
        if (evt_in && ((k - 1) % 4) == 0) begin
          if ((((k - 1) / 4 + 1) % per) == 0 && k + 2 <= ncyc) begin
            exp_hi.push_back(k + 2);
            pushed++;
          end
        end
      end
    end
    @(posedge clk);
    #1 armed = 1'b0;
    evt_in = 1'b0;
    check({tag, " lo left"}, exp_lo.size(), 0);
    check({tag, " hi left"}, exp_hi.size(), 0);
    check({tag, " pulse total"}, seen, pushed);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11: reset state
    check("R11 lo_flag", lo_flag, 0);
    check("R11 hi_flag", hi_flag, 0);
    check("R11 lo_pulse", lo_pulse, 0);
    check("R11 hi_pulse", hi_pulse, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R11 flags after release", {lo_flag, hi_flag}, 0);

    // R1 R4 R9 R2: split timers, P=1, period 24 and 40
    run_case("R1 R4 R9", 0, 1, 2, 4, 130, 0, 1'b1);
    // R3: match 0 pulses every increment, high match 255
    run_case("R3", 0, 0, 0, 255, 1030, 0, 1'b1);
    // R2: cycle tick held low, nothing advances
    cyc_tick = 1'b0;
    run_case("R2 hold", 0, 0, 0, 0, 60, 0, 1'b0);
    cyc_tick = 1'b1;
    // R6: cascaded timer, value 259, period 1040
    run_case("R6", 2, 0, 3, 1, 2200, 0, 1'b1);
    // R5 R8: timer plus event counter
    run_case("R5 R8", 1, 2, 1, 2, 48, 10, 1'b1);
    // R7 R8: cascaded event counter with carry, hit on event 259
    run_case("R7 R8", 3, 0, 2, 1, 1044, 260, 1'b1);

    // R10: flag latching, clearing and set-over-clear priority
    clr_lo = 1'b1; clr_hi = 1'b1;
    wr(2'd1, 8'd0); wr(2'd2, 8'd0); wr(2'd3, 8'd255);
    wr(2'd0, 8'd0);
    repeat (4) @(posedge clk);
    @(negedge clk);
    check("R10 set wins over clear", lo_flag, 1);
    @(negedge clk);
    check("R10 clear", lo_flag, 0);
    clr_lo = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R10 set", lo_flag, 1);
    repeat (2) @(posedge clk);
    @(negedge clk);
    check("R10 latched", lo_flag, 1);
    clr_lo = 1'b1;
    @(negedge clk);
    check("R10 cleared", lo_flag, 0);
    check("R10 hi held clear", hi_flag, 0);
    clr_lo = 1'b0; clr_hi = 1'b0;

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule